// File: doc/BRIEF.md
# Cascaded Event Interrupt Aggregator

This block gathers single-cycle event pulses from many on-chip sources into three 32-bit pending words and drives three level interrupt requests. A 7-bit event number picks one pending bit; each interrupt request has its own enable mask spanning all three words. Requests are combinational from the registered pending and mask state, so they follow any change in either.

Word 0 doubles as a summary: two of its top bits record that word 1 or word 2 holds something. Software sees every word and every mask through a small register port. Each pending word has its own clear rule. Word 0 is write-one-to-clear except for its two summary bits. Word 1 cannot be changed by software. Word 2 is write-one-to-clear and drops its summary bit once it becomes empty. A hardware clear port removes single events and keeps the summary bits consistent.

Top module: `evt_irq_aggregator`

## Requirements
- R1: An event pulse with `evt_num` sets pending word `evt_num[6:5]`, bit `evt_num[4:0]`, visible the cycle after the pulse; a word select of 3 changes nothing.
- R2: An event landing in word 1 also sets word 0 bit 30; an event landing in word 2 also sets word 0 bit 31.
- R3: Each of `irq_a`, `irq_b`, `irq_c` is high exactly when some pending bit is also set in that output's mask, with no added register stage.
- R4: A register write to address 0 clears the word 0 bits written as one, except bits 31 and 30, which keep their value.
- R5: A register write to address 1 leaves word 1 unchanged.
- R6: A register write to address 2 clears the word 2 bits written as one; if word 2 is then zero, word 0 bit 31 is cleared too.
- R7: A `clr_valid` pulse clears the bit chosen by `clr_num` (same encoding as R1); if that empties word 1 or word 2, word 0 bit 30 or bit 31 is cleared as well.
- R8: Mask words are written and read at addresses 4-6 (output A), 8-10 (B) and 12-14 (C), word index in `reg_addr[1:0]`; a mask write changes the outputs in the next cycle without any new event.
- R9: When an event and a software or hardware clear hit the same bit in one cycle, the bit ends up set.
- R10: `reg_rdata` is registered and shows the word addressed in the previous cycle (addresses 0-2 the pending words); any address with `reg_addr[1:0]` equal to 3 reads zero and ignores writes.
- R11: After reset all pending words and masks are zero, all requests are low and `reg_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_num | input | 7 | Event number: word select [6:5], bit select [4:0] |
| clr_valid | input | 1 | One-cycle hardware clear strobe |
| clr_num | input | 7 | Number of the event to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: group [3:2], word [1:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |
| irq_c | output | 1 | Interrupt request C |

## Verification
Every event, clear and register write lands in state at the next clock edge, so pending bits and the three requests are due one cycle after the stimulus, while read data takes one further cycle because the read mux is registered. The bench drives each stimulus for exactly one cycle on the falling edge and samples requests on the very next falling edge, while reads set the address on one falling edge and sample `reg_rdata` on the following one. Corner cases such as a clear colliding with an event, or a word emptying and dropping its summary bit, are read back through the register port in the cycle after they occur.

// File: rtl/eia_pkg.sv
package eia_pkg;
  parameter int EIA_WORD_W    = 32;
  parameter int EIA_NUM_WORDS = 3;
  parameter int EIA_NUM_OUT   = 3;
  localparam int EIA_BSEL_W   = $clog2(EIA_WORD_W);
  localparam int EIA_WSEL_W   = $clog2(EIA_NUM_WORDS + 1);
  localparam int EIA_NUM_W    = EIA_WSEL_W + EIA_BSEL_W;
  localparam int EIA_GSEL_W   = $clog2(EIA_NUM_OUT + 1);
  localparam int EIA_ADDR_W   = EIA_GSEL_W + EIA_WSEL_W;
endpackage

// File: rtl/eia_onehot.sv
module eia_onehot #(
  parameter int WORD_W    = eia_pkg::EIA_WORD_W,
  parameter int NUM_WORDS = eia_pkg::EIA_NUM_WORDS,
  parameter int NUM_W     = eia_pkg::EIA_NUM_W
) (
  input  logic                        valid,
  input  logic [NUM_W-1:0]            num,
  output logic [NUM_WORDS*WORD_W-1:0] vec
);
  localparam int BSEL_W = $clog2(WORD_W);
  localparam int WSEL_W = NUM_W - BSEL_W;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      assign vec[w*WORD_W + b] = valid
                                 && (num[NUM_W-1:BSEL_W] == WSEL_W'(w))
                                 && (num[BSEL_W-1:0] == BSEL_W'(b));
    end
  end
endmodule

// File: rtl/eia_pending.sv
module eia_pending #(
  parameter int WORD_W    = eia_pkg::EIA_WORD_W,
  parameter int NUM_WORDS = eia_pkg::EIA_NUM_WORDS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_WORDS*WORD_W-1:0] set_flat,
  input  logic [NUM_WORDS*WORD_W-1:0] hclr_flat,
  input  logic [NUM_WORDS-1:0]        sw_wr,
  input  logic [WORD_W-1:0]           sw_data,
  output logic [NUM_WORDS*WORD_W-1:0] pend_flat
);
  localparam int SUM2 = WORD_W - 1;   // summary of word 2
  localparam int SUM1 = WORD_W - 2;   // summary of word 1

  logic [NUM_WORDS-1:0][WORD_W-1:0] set_w, hclr_w, swclr_w, nxt_w, pend_q;
  logic drop1, drop2;

  assign set_w     = set_flat;
  assign hclr_w    = hclr_flat;
  assign pend_flat = pend_q;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      swclr_w[w] = sw_wr[w] ? sw_data : '0;
    end
    swclr_w[0][SUM2] = 1'b0;          // summary bits are protected
    swclr_w[0][SUM1] = 1'b0;
    swclr_w[1]       = '0;            // word 1 is read-only for software
    for (int w = 0; w < NUM_WORDS; w++) begin
      nxt_w[w] = (pend_q[w] & ~swclr_w[w] & ~hclr_w[w]) | set_w[w];
    end
    drop1 = (|hclr_w[1]) && !(|nxt_w[1]);
    drop2 = ((|hclr_w[2]) || sw_wr[2]) && !(|nxt_w[2]);
    nxt_w[0][SUM1] = (pend_q[0][SUM1] & ~hclr_w[0][SUM1] & ~drop1)
                     | set_w[0][SUM1] | (|set_w[1]);
    nxt_w[0][SUM2] = (pend_q[0][SUM2] & ~hclr_w[0][SUM2] & ~drop2)
                     | set_w[0][SUM2] | (|set_w[2]);
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= nxt_w;
  end

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (|set_flat) |=> ((pend_flat & $past(set_flat)) == $past(set_flat))); // R1
  AST_CASC_W1: assert property (@(posedge clk) disable iff (rst)
    (|set_w[1]) |=> pend_q[0][SUM1]); // R2
  AST_CASC_W2: assert property (@(posedge clk) disable iff (rst)
    (|set_w[2]) |=> pend_q[0][SUM2]); // R2
  AST_SUM_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (sw_wr[0] && !(|hclr_w[2]) && !hclr_w[0][SUM2] && pend_q[0][SUM2])
    |=> pend_q[0][SUM2]); // R4
  AST_W1_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (sw_wr[1] && !(|hclr_w[1]) && !(|set_w[1])) |=> $stable(pend_q[1])); // R5
endmodule

// File: rtl/eia_mask_bank.sv
module eia_mask_bank #(
  parameter int WORD_W    = eia_pkg::EIA_WORD_W,
  parameter int NUM_WORDS = eia_pkg::EIA_NUM_WORDS,
  parameter int WSEL_W    = eia_pkg::EIA_WSEL_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [WSEL_W-1:0]           widx,
  input  logic [WORD_W-1:0]           wdata,
  output logic [NUM_WORDS*WORD_W-1:0] mask_flat
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] mask_q;
  assign mask_flat = mask_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mw
    always_ff @(posedge clk) begin
      if (rst)                                     mask_q[w] <= '0;
      else if (wr_en && (widx == WSEL_W'(w)))      mask_q[w] <= wdata;
    end
  end
endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator #(
  parameter int WORD_W    = eia_pkg::EIA_WORD_W,
  parameter int NUM_WORDS = eia_pkg::EIA_NUM_WORDS,
  parameter int NUM_OUT   = eia_pkg::EIA_NUM_OUT,
  parameter int NUM_W     = eia_pkg::EIA_NUM_W,
  parameter int WSEL_W    = eia_pkg::EIA_WSEL_W,
  parameter int GSEL_W    = eia_pkg::EIA_GSEL_W,
  parameter int ADDR_W    = eia_pkg::EIA_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [NUM_W-1:0]  evt_num,
  input  logic              clr_valid,
  input  logic [NUM_W-1:0]  clr_num,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_c
);
  localparam int FLAT_W = NUM_WORDS * WORD_W;

  logic [FLAT_W-1:0]                set_flat, hclr_flat, pend_flat;
  logic [NUM_OUT-1:0][FLAT_W-1:0]   mask_flat;
  logic [NUM_WORDS-1:0][WORD_W-1:0] pend_w;
  logic [NUM_OUT-1:0][NUM_WORDS-1:0][WORD_W-1:0] mask_w;
  logic [NUM_OUT-1:0]               irq_vec;
  logic [NUM_WORDS-1:0]             pend_wr;
  logic [GSEL_W-1:0]                gsel;
  logic [WSEL_W-1:0]                widx;
  logic                             word_ok;
  logic [WORD_W-1:0]                rd_sel;

  assign gsel    = reg_addr[ADDR_W-1:WSEL_W];
  assign widx    = reg_addr[WSEL_W-1:0];
  assign word_ok = (widx < WSEL_W'(NUM_WORDS));

  eia_onehot #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_W(NUM_W)) u_set_dec (
    .valid(evt_valid), .num(evt_num), .vec(set_flat));
  eia_onehot #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_W(NUM_W)) u_clr_dec (
    .valid(clr_valid), .num(clr_num), .vec(hclr_flat));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_pwr
    assign pend_wr[w] = reg_wr && (gsel == '0) && (widx == WSEL_W'(w));
  end

  eia_pending #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_pend (
    .clk(clk), .rst(rst), .set_flat(set_flat), .hclr_flat(hclr_flat),
    .sw_wr(pend_wr), .sw_data(reg_wdata), .pend_flat(pend_flat));

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    eia_mask_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .WSEL_W(WSEL_W)) u_mask (
      .clk(clk), .rst(rst),
      .wr_en(reg_wr && (gsel == GSEL_W'(o + 1))),
      .widx(widx), .wdata(reg_wdata), .mask_flat(mask_flat[o]));
    assign mask_w[o]  = mask_flat[o];
    assign irq_vec[o] = |(pend_flat & mask_flat[o]);
  end

  assign pend_w = pend_flat;
  assign irq_a  = irq_vec[0];
  assign irq_b  = irq_vec[1];
  assign irq_c  = irq_vec[2];

  always_comb begin
    rd_sel = '0;
    if (word_ok) begin
      if (gsel == '0)                           rd_sel = pend_w[widx];
      else if (gsel <= GSEL_W'(NUM_OUT))        rd_sel = mask_w[gsel - 1'b1][widx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_sel;
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pend_flat == '0) |-> (irq_vec == '0)); // R3
  AST_HOLE_READ: assert property (@(posedge clk) disable iff (rst)
    (widx == '1) |=> (reg_rdata == '0)); // R10
endmodule

// File: tb/evt_irq_aggregator_tb.sv
`timescale 1ns/100ps
module evt_irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0, clr_valid = 1'b0, reg_wr = 1'b0;
  logic [6:0]  evt_num = '0, clr_num = '0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq_a, irq_b, irq_c;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_irq_aggregator u_dut (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_num(evt_num),
    .clr_valid(clr_valid), .clr_num(clr_num), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_a(irq_a), .irq_b(irq_b), .irq_c(irq_c));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One-cycle stimulus; returns on the falling edge after the capturing edge.
  task automatic cyc(input logic ev, input logic [6:0] en, input logic cv, input logic [6:0] cn,
                     input logic w, input logic [3:0] a, input logic [31:0] d);
    evt_valid = ev; evt_num = en; clr_valid = cv; clr_num = cn;
    reg_wr = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    evt_valid = 0; clr_valid = 0; reg_wr = 0;
  endtask

  task automatic evt(input logic [6:0] n);  cyc(1, n, 0, 0, 0, 0, 0); endtask
  task automatic hclr(input logic [6:0] n); cyc(0, 0, 1, n, 0, 0, 0); endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d); cyc(0, 0, 0, 0, 1, a, d); endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 rdata", reg_rdata, 0);
    chk("R11 irqs", {29'd0, irq_a, irq_b, irq_c}, 0);
    for (int g = 0; g < 4; g++)
      for (int w = 0; w < 3; w++) rd_chk("R11 reg", 4'(g*4 + w), 0);
  endtask

  task automatic t_decode();
    do_reset();
    evt(7'd5);       rd_chk("R1 word0", 0, 32'h0000_0020);
    evt(7'd33);      rd_chk("R1 word1", 1, 32'h0000_0002);
    rd_chk("R2 bit30", 0, 32'h4000_0020);
    evt(7'd71);      rd_chk("R1 word2", 2, 32'h0000_0080);
    rd_chk("R2 bit31", 0, 32'hC000_0020);
    evt(7'd100);
    rd_chk("R1 word3 ignored w0", 0, 32'hC000_0020);
    rd_chk("R1 word3 ignored w1", 1, 32'h0000_0002);
    rd_chk("R1 word3 ignored w2", 2, 32'h0000_0080);
  endtask

  task automatic t_irq();
    do_reset();
    evt(7'd33);
    chk("R3 no mask", {29'd0, irq_a, irq_b, irq_c}, 0);
    wr(4'd5, 32'h2);
    chk("R8 live rise A", {31'd0, irq_a}, 1);
    chk("R3 B low", {31'd0, irq_b}, 0);
    wr(4'd8, 32'h4000_0000);
    chk("R3 B via summary", {31'd0, irq_b}, 1);
    wr(4'd14, 32'h1);
    chk("R3 C idle", {31'd0, irq_c}, 0);
    evt(7'd64);
    chk("R3 C event", {31'd0, irq_c}, 1);
    wr(4'd5, 32'h0);
    chk("R8 live fall A", {31'd0, irq_a}, 0);
    rd_chk("R8 readback B0", 4'd8, 32'h4000_0000);
    rd_chk("R8 readback C2", 4'd14, 32'h1);
  endtask

  task automatic t_sw_clear();
    do_reset();
    evt(7'd1); evt(7'd2); evt(7'd33); evt(7'd71); evt(7'd72);
    rd_chk("R4 before", 0, 32'hC000_0006);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R4 protect", 0, 32'hC000_0000);
    wr(4'd1, 32'hFFFF_FFFF);
    rd_chk("R5 word1 kept", 1, 32'h0000_0002);
    wr(4'd2, 32'h80);
    rd_chk("R6 partial", 2, 32'h0000_0100);
    rd_chk("R6 bit31 kept", 0, 32'hC000_0000);
    wr(4'd2, 32'h100);
    rd_chk("R6 empty", 2, 32'h0);
    rd_chk("R6 bit31 dropped", 0, 32'h4000_0000);
  endtask

  task automatic t_hw_clear();
    do_reset();
    evt(7'd33); evt(7'd34);
    hclr(7'd33);
    rd_chk("R7 word1 partial", 1, 32'h4);
    rd_chk("R7 bit30 kept", 0, 32'h4000_0000);
    hclr(7'd34);
    rd_chk("R7 bit30 dropped", 0, 32'h0);
    evt(7'd95); hclr(7'd95);
    rd_chk("R7 bit31 dropped", 0, 32'h0);
  endtask

  task automatic t_collide();
    do_reset();
    evt(7'd3);
    cyc(1, 7'd3, 0, 0, 1, 4'd0, 32'h8);
    rd_chk("R9 sw clear loses", 0, 32'h8);
    cyc(1, 7'd10, 1, 7'd10, 0, 0, 0);
    rd_chk("R9 hw clear loses", 0, 32'h408);
  endtask

  task automatic t_holes();
    do_reset();
    wr(4'd4, 32'h55);
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    rd_chk("R10 hole read", 4'd7, 0);
    rd_chk("R10 hole read pend", 4'd3, 0);
    rd_chk("R10 neighbour kept", 4'd4, 32'h55);
    rd_chk("R10 neighbour kept A1", 4'd5, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_decode();
    t_irq();
    t_sw_clear();
    t_hw_clear();
    t_collide();
    t_holes();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule